// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Port for a Synthesizer Control Word

This block is the programming front end for a frequency synthesizer. A host loads a 20-bit control word one bit at a time on a slow serial clock while a load line is held low. A steering line chooses the target register. With the line low, the bits go into the primary shift register. With the line high, they go into an 8-bit enhancement register. All serial pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer before any edge on it is detected.

The primary word does not drive the synthesizer directly. It is copied into a secondary holding register when the load line rises, or when a separate hop strobe rises. This lets a new word be shifted in while the previous one stays in force. A mode pin can instead select a parallel path, where the K, M and A counter values come straight from pins. The output word is registered, so it changes cleanly in one system-clock cycle. A prescaler-enable pin (active low) is also registered and reported as a bypass flag.

Top module: `synth_cfg_port`

## Requirements
- R1: With `ld_n` low and `enh_sel` low, each rising edge of `ser_clk` shifts `ser_dat` into bit 0 of the 20-bit primary register, moving earlier bits up. The first bit sent therefore ends in bit 19 (MSB first).
- R2: While `ld_n` is high, `ser_clk` edges change neither the primary nor the enhancement register.
- R3: With `ld_n` low and `enh_sel` high, bits shift MSB first into the 8-bit enhancement register, which is visible on `enh_word`. The primary register is left unchanged.
- R4: The secondary register takes the primary contents on a rising edge of `ld_n` or of `hop_stb`, and at no other time. Shifting alone never changes the serial-mode output.
- R5: Rising edges of `ld_n` and `hop_stb` that land in the same system-clock cycle cause exactly one transfer of the current primary word.
- R6: In serial mode (`par_mode` low), the secondary word S drives the output fields as follows: `cw_m` = S[19:11], `cw_a` = S[10:7], `cw_k` = S[6:0] zero-extended to 18 bits.
- R7: With `par_mode` high, `cw_k`, `cw_m` and `cw_a` equal `par_k`, `par_m` and `par_a` (bit 0 = LSB), one clock after the pins are sampled. Clearing `par_mode` returns the outputs to the secondary word.
- R8: `presc_bypass` is high one clock after `pre_en_n` is sampled high, and low one clock after it is sampled low.
- R9: Reset clears the primary, enhancement and secondary registers, so all control-word outputs and `enh_word` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ld_n | input | 1 | Load line: low allows shifting, rising edge transfers |
| enh_sel | input | 1 | Steers serial data to the enhancement register when high |
| hop_stb | input | 1 | Rising edge transfers primary to secondary |
| par_mode | input | 1 | High selects parallel counter pins |
| pre_en_n | input | 1 | Prescaler enable, active low |
| par_k | input | 18 | Parallel K value |
| par_m | input | 9 | Parallel M value |
| par_a | input | 4 | Parallel A value |
| cw_k | output | 18 | Control word K field |
| cw_m | output | 9 | Control word M field |
| cw_a | output | 4 | Control word A field |
| enh_word | output | 8 | Enhancement register contents |
| presc_bypass | output | 1 | Prescaler bypassed |

## Verification
The bench uses the default 20-bit primary and 8-bit enhancement widths with two synchronizer stages. These sizes are small enough to sweep all 256 enhancement bytes. They also allow a walking one through every primary bit position, which exposes any error in bit order or field placement. All 16 A values are driven in parallel mode. Separate cases cover transfer by load, by hop strobe, and by both strobes in the same cycle.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int K_W = 18;
  localparam int M_W = 9;
  localparam int A_W = 4;
  localparam int CW_W = K_W + M_W + A_W;

  typedef struct packed {
    logic [K_W-1:0] k;
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
  } cw_t;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/synth_cfg_edge.sv
module synth_cfg_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end
  assign rise = lvl & ~prev;
endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift #(
  parameter int PRI_W = 20,
  parameter int ENH_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             bit_val,
  input  logic             load_lvl,
  input  logic             to_enh,
  output logic [PRI_W-1:0] pri,
  output logic [ENH_W-1:0] enh
);
  logic take;
  assign take = bit_stb && !load_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri <= '0;
      enh <= '0;
    end else if (take) begin
      if (to_enh) enh <= {enh[ENH_W-2:0], bit_val};
      else        pri <= {pri[PRI_W-2:0], bit_val};
    end
  end

  // R2: a load level seen by this stage freezes both registers
  p_hold_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_lvl |=> ($stable(pri) && $stable(enh)));
  // R3: a bit steered to the enhancement register leaves primary alone
  p_enh_spares_pri_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !load_lvl && to_enh) |=> $stable(pri));
  // R1: a bit steered to primary leaves enhancement alone
  p_pri_spares_enh_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !load_lvl && !to_enh) |=> $stable(enh));
endmodule

// File: rtl/synth_cfg_xfer.sv
module synth_cfg_xfer
  import synth_cfg_pkg::*;
#(
  parameter int PRI_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_rise,
  input  logic             hop_rise,
  input  logic [PRI_W-1:0] pri,
  input  logic             par_sel,
  input  cw_t              par_cw,
  input  logic             pre_en_n,
  output cw_t              cw,
  output logic             bypass
);
  localparam int KL_W = PRI_W - M_W - A_W;

  logic [PRI_W-1:0] sec;

  function automatic cw_t map_word(input logic [PRI_W-1:0] w);
    cw_t c;
    c = '0;
    c.m = w[PRI_W-1 -: M_W];
    c.a = w[KL_W +: A_W];
    c.k[KL_W-1:0] = w[KL_W-1:0];
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   sec <= '0;
    else if (ld_rise || hop_rise) sec <= pri;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw     <= '0;
      bypass <= 1'b0;
    end else begin
      cw     <= par_sel ? par_cw : map_word(sec);
      bypass <= pre_en_n;
    end
  end

  // R4: without a strobe edge the holding register keeps its value
  p_sec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_rise || hop_rise) |=> $stable(sec));
  // R5: coincident strobes still yield the primary word once
  p_dual_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && hop_rise) |=> (sec == $past(pri)));
  // R7: parallel mode output tracks the pins one cycle later
  p_par_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    par_sel |=> (cw == $past(par_cw)));
  // R8: bypass flag follows the active-low enable
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en_n |=> bypass);
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int PRI_W       = 20,
  parameter int ENH_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ld_n,
  input  logic             enh_sel,
  input  logic             hop_stb,
  input  logic             par_mode,
  input  logic             pre_en_n,
  input  logic [K_W-1:0]   par_k,
  input  logic [M_W-1:0]   par_m,
  input  logic [A_W-1:0]   par_a,
  output logic [K_W-1:0]   cw_k,
  output logic [M_W-1:0]   cw_m,
  output logic [A_W-1:0]   cw_a,
  output logic [ENH_W-1:0] enh_word,
  output logic             presc_bypass
);
  localparam int NSYNC = 5;
  localparam int NEDGE = 3;

  logic [NSYNC-1:0] s_lvl;
  logic [NEDGE-1:0] s_rise;
  logic [PRI_W-1:0] pri;
  cw_t              par_cw;
  cw_t              cw;

  synth_cfg_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({ser_dat, enh_sel, hop_stb, ld_n, ser_clk}),
    .q   (s_lvl)
  );

  synth_cfg_edge #(.N(NEDGE)) u_edge (
    .clk  (clk),
    .rst_n (rst_n),
    .lvl  (s_lvl[2:0]),
    .rise (s_rise)
  );

  synth_cfg_shift #(.PRI_W(PRI_W), .ENH_W(ENH_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_stb  (s_rise[0]),
    .bit_val  (s_lvl[4]),
    .load_lvl (s_lvl[1]),
    .to_enh   (s_lvl[3]),
    .pri      (pri),
    .enh      (enh_word)
  );

  assign par_cw.k = par_k;
  assign par_cw.m = par_m;
  assign par_cw.a = par_a;

  synth_cfg_xfer #(.PRI_W(PRI_W)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_rise  (s_rise[1]),
    .hop_rise (s_rise[2]),
    .pri      (pri),
    .par_sel  (par_mode),
    .par_cw   (par_cw),
    .pre_en_n (pre_en_n),
    .cw       (cw),
    .bypass   (presc_bypass)
  );

  assign cw_k = cw.k;
  assign cw_m = cw.m;
  assign cw_a = cw.a;
endmodule

// File: tb/synth_cfg_port_bench.sv
module synth_cfg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_dat = 1'b0, ld_n = 1'b0, enh_sel = 1'b0;
  logic        hop_stb = 1'b0, par_mode = 1'b0, pre_en_n = 1'b0;
  logic [17:0] par_k = '0;
  logic [8:0]  par_m = '0;
  logic [3:0]  par_a = '0;
  logic [17:0] cw_k;
  logic [8:0]  cw_m;
  logic [3:0]  cw_a;
  logic [7:0]  enh_word;
  logic        presc_bypass;

  int checks = 0;
  int errors = 0;
  logic [19:0] last_pri;

  always #5 clk = ~clk;

  synth_cfg_port u_synth_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ld_n(ld_n),
    .enh_sel(enh_sel), .hop_stb(hop_stb), .par_mode(par_mode), .pre_en_n(pre_en_n),
    .par_k(par_k), .par_m(par_m), .par_a(par_a), .cw_k(cw_k), .cw_m(cw_m),
    .cw_a(cw_a), .enh_word(enh_word), .presc_bypass(presc_bypass)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input logic [19:0] w);
    chk(tag, {14'd0, cw_k}, {25'd0, w[6:0]});
    chk(tag, {23'd0, cw_m}, {23'd0, w[19:11]});
    chk(tag, {28'd0, cw_a}, {28'd0, w[10:7]});
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;  wclk(3);
    ser_clk = 1'b1; wclk(3);
    ser_clk = 1'b0; wclk(3);
  endtask

  task automatic send_pri(input logic [19:0] v);
    enh_sel = 1'b0; ld_n = 1'b0; wclk(4);
    for (int i = 19; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_enh(input logic [7:0] v);
    enh_sel = 1'b1; ld_n = 1'b0; wclk(4);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    enh_sel = 1'b0; wclk(4);
  endtask

  task automatic load_rise();
    ld_n = 1'b1; wclk(8);
  endtask

  task automatic hop_pulse();
    hop_stb = 1'b1; wclk(6);
    hop_stb = 1'b0; wclk(6);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    wclk(3);
    // R9: reset state
    chk_word("R9 reset word", 20'd0);
    chk("R9 reset enh", {24'd0, enh_word}, 32'd0);
    chk("R8 reset bypass", {31'd0, presc_bypass}, 32'd0);
    rst_n = 1'b1; wclk(3);
    chk_word("R9 after reset", 20'd0);

    // R1 R6 R4: walking one plus patterns through the primary path
    for (int i = 0; i < 23; i++) begin
      logic [19:0] v;
      if (i < 20) v = 20'd1 << i;
      else if (i == 20) v = 20'hABCDE;
      else if (i == 21) v = 20'hFFFFF;
      else v = 20'h5A5A5;
      send_pri(v);
      wclk(6);
      chk_word("R4 shift only keeps old word", last_pri);
      load_rise();
      chk_word("R1 R6 loaded word", v);
      last_pri = v;
    end

    // R3: all enhancement bytes, primary untouched
    for (int e = 0; e < 256; e++) begin
      send_enh(e[7:0]);
      chk("R3 enh value", {24'd0, enh_word}, {24'd0, e[7:0]});
    end
    chk_word("R3 output held", last_pri);
    hop_pulse();
    chk_word("R3 primary untouched", last_pri);

    // R2: serial clock ignored while load line high
    ld_n = 1'b1; wclk(4);
    for (int i = 0; i < 10; i++) send_bit(i[0] ^ 1'b1);
    enh_sel = 1'b1; wclk(4);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    enh_sel = 1'b0; wclk(4);
    hop_pulse();
    chk_word("R2 primary frozen", last_pri);
    chk("R2 enh frozen", {24'd0, enh_word}, 32'd255);

    // R4: hop strobe transfer with load line low
    send_pri(20'h13579);
    hop_pulse();
    chk_word("R4 hop transfer", 20'h13579);

    // R5: coincident strobe edges
    send_pri(20'h2468A);
    ld_n = 1'b1; hop_stb = 1'b1; wclk(8);
    chk_word("R5 dual strobe", 20'h2468A);
    hop_stb = 1'b0; wclk(4);
    chk_word("R5 word stable", 20'h2468A);

    // R7: parallel mode
    par_mode = 1'b1;
    for (int a = 0; a < 16; a++) begin
      par_a = a[3:0];
      par_m = 9'(a * 37 + 5);
      par_k = 18'(a * 9973 + 1);
      wclk(1);
      chk("R7 par k", {14'd0, cw_k}, {14'd0, 18'(a * 9973 + 1)});
      chk("R7 par m", {23'd0, cw_m}, {23'd0, 9'(a * 37 + 5)});
      chk("R7 par a", {28'd0, cw_a}, {28'd0, a[3:0]});
    end
    par_mode = 1'b0; wclk(1);
    chk_word("R7 back to serial", 20'h2468A);

    // R8: prescaler bypass
    pre_en_n = 1'b1; wclk(1);
    chk("R8 bypass high", {31'd0, presc_bypass}, 32'd1);
    pre_en_n = 1'b0; wclk(1);
    chk("R8 bypass low", {31'd0, presc_bypass}, 32'd0);

    // R9: mid-run reset
    rst_n = 1'b0; wclk(2);
    chk_word("R9 mid reset", 20'd0);
    chk("R9 mid reset enh", {24'd0, enh_word}, 32'd0);

    report();
    $finish;
  end
endmodule